// File: doc/BRIEF.md
# SIMD Lane Replicate and Bit-Reverse Unit

This unit sits in the execute stage of a RISC datapath that has a DSP extension. It is purely combinational. Each cycle it takes an operation code, one register operand, the 10-bit immediate field cut from instruction bits [25:16], and the destination register index. From these it forms one result word. Its two jobs are reversing the bit order of the operand's low halfword, and filling the result with copies of a byte, halfword or word lane. The lane value comes either from the immediate or from the low bits of the operand.

A mode input selects the result behaviour. With `wide_mode` high the whole 64-bit result is filled with lanes. With it low the result is built at 32 bits and sign-extended to the datapath width. The word-replicate operations exist only in wide mode, and the unit flags them as illegal in narrow mode. Instruction decode, register-file access and trap generation are left to the surrounding pipeline. The pipeline uses `wr_en` to decide whether to commit the result, and `illegal` to decide whether to raise a reserved-instruction trap.

Top module: `rbu_top`

## Requirements
- R1: Operation code 0 (bit reverse) places operand bit 15-i at result bit i for i from 0 to 15, and drives every result bit above 15 to zero, in either mode.
- R2: Operation code 1 (byte from immediate) copies immediate field bits [7:0] (instruction bits [23:16]) into all eight byte lanes in wide mode, and into the four byte lanes of the low 32 bits in narrow mode.
- R3: Operation code 2 (byte from register) copies operand bits [7:0] into every byte lane, eight in wide mode and four in narrow mode.
- R4: Operation codes 3 (halfword from immediate) and 5 (word from immediate) sign-extend the 10-bit immediate field from its bit 9 to the lane width. The result is then copied into every 16-bit or 32-bit lane.
- R5: Operation code 4 (halfword from register) copies operand bits [15:0] into every 16-bit lane, four in wide mode and two in narrow mode.
- R6: Operation code 6 (word from register) copies operand bits [31:0] into both 32-bit halves of the result, in wide mode only.
- R7: With `wide_mode` low (narrow mode), every legal result has bits [63:32] equal to copies of result bit 31.
- R8: When `dst_idx` is 0 the operation is a no-op: `wr_en` is 0 and `result` is all zeros.
- R9: Operation codes 5 and 6 with `wide_mode` low, and the reserved code 7 in either mode, drive `illegal` to 1, `wr_en` to 0 and `result` to zero. Every other code drives `illegal` to 0.
- R10: A legal operation with a nonzero `dst_idx` drives `wr_en` to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Operation code (0 to 7, see requirements) |
| wide_mode | input | 1 | 1 = 64-bit result behaviour, 0 = 32-bit sign-extended |
| opnd | input | 64 | Register operand |
| imm_field | input | 10 | Instruction bits [25:16] |
| dst_idx | input | 5 | Destination register index |
| result | output | 64 | Result word |
| wr_en | output | 1 | Result should be committed |
| illegal | output | 1 | Operation not available in the current mode |

## Verification
The checker's properties hold only while every input is a known value. Each property is guarded so that it stays quiet while the inputs are still unknown at start-up. The bench drives every input on the falling edge before any result is compared, so all inputs are defined whenever an item is checked. The random phase draws all eight operation codes, both modes, the full 10-bit immediate range (bit 9 set in about half the draws) and a zero destination index now and then. Legal, no-op and illegal cases are therefore interleaved, not run in separate phases.

// File: rtl/rbu_pkg.sv
package rbu_pkg;

    localparam int RBU_XLEN     = 64;
    localparam int RBU_NARROW_W = 32;
    localparam int RBU_IMM_W    = 10;
    localparam int RBU_IDX_W    = 5;
    localparam int RBU_REV_W    = 16;
    localparam int RBU_BYTE_W   = 8;
    localparam int RBU_KINDS    = 3;

    typedef enum logic [2:0] {
        OP_BREV   = 3'd0,
        OP_REPI_B = 3'd1,
        OP_REPR_B = 3'd2,
        OP_REPI_H = 3'd3,
        OP_REPR_H = 3'd4,
        OP_REPI_W = 3'd5,
        OP_REPR_W = 3'd6,
        OP_RSVD   = 3'd7
    } rbu_op_e;

    typedef enum logic [1:0] {
        LANE_B    = 2'd0,
        LANE_H    = 2'd1,
        LANE_W    = 2'd2,
        LANE_NONE = 2'd3
    } lane_e;

    typedef struct packed {
        lane_e lane;
        logic  from_imm;
        logic  is_brev;
        logic  wide_only;
        logic  known;
    } op_dec_t;

    function automatic op_dec_t decode_op(rbu_op_e op);
        op_dec_t d;
        d = '{lane: LANE_NONE, from_imm: 1'b0, is_brev: 1'b0,
              wide_only: 1'b0, known: 1'b1};
        case (op)
            OP_BREV:   d.is_brev = 1'b1;
            OP_REPI_B: begin d.lane = LANE_B; d.from_imm = 1'b1; end
            OP_REPR_B: d.lane = LANE_B;
            OP_REPI_H: begin d.lane = LANE_H; d.from_imm = 1'b1; end
            OP_REPR_H: d.lane = LANE_H;
            OP_REPI_W: begin d.lane = LANE_W; d.from_imm = 1'b1; d.wide_only = 1'b1; end
            OP_REPR_W: begin d.lane = LANE_W; d.wide_only = 1'b1; end
            default:   d.known = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rbu_bitrev.sv
module rbu_bitrev #(
    parameter int XLEN  = rbu_pkg::RBU_XLEN,
    parameter int REV_W = rbu_pkg::RBU_REV_W
) (
    input  logic [REV_W-1:0] src,
    output logic [XLEN-1:0]  rev
);
    localparam int PAD_W = XLEN - REV_W;

    logic [REV_W-1:0] flipped;

    for (genvar i = 0; i < REV_W; i++) begin : g_flip
        assign flipped[i] = src[REV_W-1-i];
    end

    assign rev = {{PAD_W{1'b0}}, flipped};

endmodule

// File: rtl/rbu_replicate.sv
module rbu_replicate #(
    parameter int XLEN     = rbu_pkg::RBU_XLEN,
    parameter int NARROW_W = rbu_pkg::RBU_NARROW_W,
    parameter int LANE_W   = 8
) (
    input  logic [LANE_W-1:0] lane_val,
    output logic [XLEN-1:0]   wide_rep,
    output logic [XLEN-1:0]   narrow_rep
);
    localparam int WIDE_N   = XLEN / LANE_W;
    localparam int NARROW_N = (NARROW_W / LANE_W) > 0 ? (NARROW_W / LANE_W) : 1;
    localparam int EXT_W    = XLEN - NARROW_W;

    logic [NARROW_W-1:0] narrow_core;

    for (genvar w = 0; w < WIDE_N; w++) begin : g_wide
        assign wide_rep[w*LANE_W +: LANE_W] = lane_val;
    end

    for (genvar n = 0; n < NARROW_N; n++) begin : g_narrow
        assign narrow_core[n*LANE_W +: LANE_W] = lane_val;
    end

    assign narrow_rep = {{EXT_W{narrow_core[NARROW_W-1]}}, narrow_core};

endmodule

// File: rtl/rbu_result_sel.sv
module rbu_result_sel
    import rbu_pkg::*;
#(
    parameter int XLEN  = RBU_XLEN,
    parameter int IDX_W = RBU_IDX_W
) (
    input  lane_e                          lane,
    input  logic                           is_brev,
    input  logic                           wide_only,
    input  logic                           known,
    input  logic                           wide_mode,
    input  logic [IDX_W-1:0]               dst_idx,
    input  logic [XLEN-1:0]                brev_res,
    input  logic [RBU_KINDS-1:0][XLEN-1:0] wide_rep,
    input  logic [RBU_KINDS-1:0][XLEN-1:0] narrow_rep,
    output logic [XLEN-1:0]                result,
    output logic                           wr_en,
    output logic                           illegal
);
    logic [XLEN-1:0] rep_pick;

    always_comb begin
        illegal = !known || (wide_only && !wide_mode);
        wr_en   = !illegal && (dst_idx != '0);
    end

    always_comb begin
        case (lane)
            LANE_B:  rep_pick = wide_mode ? wide_rep[0] : narrow_rep[0];
            LANE_H:  rep_pick = wide_mode ? wide_rep[1] : narrow_rep[1];
            LANE_W:  rep_pick = wide_rep[2];
            default: rep_pick = '0;
        endcase
    end

    always_comb begin
        if (!wr_en)       result = '0;
        else if (is_brev) result = brev_res;
        else              result = rep_pick;
    end

endmodule

// File: rtl/rbu_top.sv
module rbu_top
    import rbu_pkg::*;
#(
    parameter int XLEN     = RBU_XLEN,
    parameter int NARROW_W = RBU_NARROW_W,
    parameter int IMM_W    = RBU_IMM_W,
    parameter int IDX_W    = RBU_IDX_W
) (
    input  logic [2:0]       op_sel,
    input  logic             wide_mode,
    input  logic [XLEN-1:0]  opnd,
    input  logic [IMM_W-1:0] imm_field,
    input  logic [IDX_W-1:0] dst_idx,
    output logic [XLEN-1:0]  result,
    output logic             wr_en,
    output logic             illegal
);
    localparam int SEXT_W = XLEN - IMM_W;
    localparam int BPAD_W = XLEN - RBU_BYTE_W;

    op_dec_t dec;
    logic [XLEN-1:0] imm_sext;
    logic [XLEN-1:0] imm_byte;
    logic [RBU_KINDS-1:0][XLEN-1:0] lane_src;
    logic [RBU_KINDS-1:0][XLEN-1:0] wide_rep;
    logic [RBU_KINDS-1:0][XLEN-1:0] narrow_rep;
    logic [XLEN-1:0] brev_res;

    assign dec      = decode_op(rbu_op_e'(op_sel));
    assign imm_sext = {{SEXT_W{imm_field[IMM_W-1]}}, imm_field};
    assign imm_byte = {{BPAD_W{1'b0}}, imm_field[RBU_BYTE_W-1:0]};

    for (genvar k = 0; k < RBU_KINDS; k++) begin : g_kind
        localparam int LW = RBU_BYTE_W << k;
        if (k == 0) begin : g_byte_src
            assign lane_src[k] = dec.from_imm ? imm_byte : opnd;
        end else begin : g_wide_src
            assign lane_src[k] = dec.from_imm ? imm_sext : opnd;
        end
        rbu_replicate #(
            .XLEN(XLEN), .NARROW_W(NARROW_W), .LANE_W(LW)
        ) u_rep (
            .lane_val  (lane_src[k][LW-1:0]),
            .wide_rep  (wide_rep[k]),
            .narrow_rep(narrow_rep[k])
        );
    end

    rbu_bitrev #(.XLEN(XLEN), .REV_W(RBU_REV_W)) u_brev (
        .src(opnd[RBU_REV_W-1:0]),
        .rev(brev_res)
    );

    rbu_result_sel #(.XLEN(XLEN), .IDX_W(IDX_W)) u_sel (
        .lane      (dec.lane),
        .is_brev   (dec.is_brev),
        .wide_only (dec.wide_only),
        .known     (dec.known),
        .wide_mode (wide_mode),
        .dst_idx   (dst_idx),
        .brev_res  (brev_res),
        .wide_rep  (wide_rep),
        .narrow_rep(narrow_rep),
        .result    (result),
        .wr_en     (wr_en),
        .illegal   (illegal)
    );

endmodule

// File: rtl/rbu_checker.sv
module rbu_checker #(
    parameter int XLEN  = 64,
    parameter int IMM_W = 10,
    parameter int IDX_W = 5
) (
    input logic [2:0]       op_sel,
    input logic             wide_mode,
    input logic [XLEN-1:0]  opnd,
    input logic [IMM_W-1:0] imm_field,
    input logic [IDX_W-1:0] dst_idx,
    input logic [XLEN-1:0]  result,
    input logic             wr_en,
    input logic             illegal
);
    logic known_in;
    assign known_in = !$isunknown({op_sel, wide_mode, opnd, imm_field, dst_idx});

    always_comb begin
        if (known_in) begin
            // R1
            a_r1_brev_low_half: assert (!(op_sel == 3'd0 && wr_en) ||
                (result[XLEN-1:16] == '0 && result[15] == opnd[0] && result[0] == opnd[15]))
                else $error("R1 bit reverse shape wrong");
            // R3
            a_r3_reg_byte_lanes: assert (!(op_sel == 3'd2 && wr_en && wide_mode) ||
                (result[63:56] == opnd[7:0] && result[31:24] == opnd[7:0]))
                else $error("R3 byte lane mismatch");
            // R4
            a_r4_imm_half_sext: assert (!(op_sel == 3'd3 && wr_en) ||
                (result[15:0] == {{6{imm_field[9]}}, imm_field}))
                else $error("R4 halfword immediate not sign extended");
            // R6
            a_r6_reg_word_halves: assert (!(op_sel == 3'd6 && wr_en) ||
                (result[63:32] == opnd[31:0] && result[31:0] == opnd[31:0]))
                else $error("R6 word halves differ");
            // R7
            a_r7_narrow_sext: assert (!(wr_en && !wide_mode) ||
                (result[XLEN-1:32] == {(XLEN-32){result[31]}}))
                else $error("R7 narrow result not sign extended");
            // R8
            a_r8_zero_dst_nop: assert (dst_idx != '0 || (!wr_en && result == '0))
                else $error("R8 zero destination wrote");
            // R9
            a_r9_illegal_quiet: assert (!illegal || (!wr_en && result == '0))
                else $error("R9 illegal op not quiet");
            // R9
            a_r9_reserved_flagged: assert (op_sel != 3'd7 || illegal)
                else $error("R9 reserved code not flagged");
        end
    end

endmodule

bind rbu_top rbu_checker #(.XLEN(XLEN), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_rbu_chk (
    .op_sel   (op_sel),
    .wide_mode(wide_mode),
    .opnd     (opnd),
    .imm_field(imm_field),
    .dst_idx  (dst_idx),
    .result   (result),
    .wr_en    (wr_en),
    .illegal  (illegal)
);

// File: tb/rbu_top_bench.sv
module rbu_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam int N_RANDOM   = 4000;

    typedef struct {
        logic [63:0] res;
        logic        we;
        logic        ill;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_sel = '0;
    logic        wide_mode = 1'b0;
    logic [63:0] opnd = '0;
    logic [9:0]  imm_field = '0;
    logic [4:0]  dst_idx = '0;
    logic [63:0] result;
    logic        wr_en;
    logic        illegal;

    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rbu_top u_rbu_top (
        .op_sel(op_sel), .wide_mode(wide_mode), .opnd(opnd),
        .imm_field(imm_field), .dst_idx(dst_idx),
        .result(result), .wr_en(wr_en), .illegal(illegal)
    );

    function automatic logic [63:0] sx32(logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    function automatic exp_t model(logic [2:0] op, logic wm, logic [63:0] a,
                                   logic [9:0] im, logic [4:0] d);
        exp_t e;
        logic [15:0] h;
        logic [31:0] w;
        logic [63:0] b;
        e.res = '0; e.we = 1'b0; e.ill = 1'b0;
        case (op)
            3'd0: e.tag = "R1"; 3'd1: e.tag = "R2"; 3'd2: e.tag = "R3";
            3'd3: e.tag = "R4"; 3'd4: e.tag = "R5"; 3'd5: e.tag = "R4";
            3'd6: e.tag = "R6"; default: e.tag = "R9";
        endcase
        if (op == 3'd7 || (!wm && (op == 3'd5 || op == 3'd6))) begin
            e.ill = 1'b1; e.tag = "R9";
            return e;
        end
        if (d == 5'd0) begin
            e.tag = "R8";
            return e;
        end
        e.we = 1'b1;
        if (!wm && op != 3'd0) e.tag = {e.tag, "/R7"};
        h = (op == 3'd3) ? {{6{im[9]}}, im} : a[15:0];
        w = (op == 3'd5) ? {{22{im[9]}}, im} : a[31:0];
        b = (op == 3'd1) ? {56'd0, im[7:0]} : {56'd0, a[7:0]};
        case (op)
            3'd0: for (int i = 0; i < 16; i++) e.res[i] = a[15-i];
            3'd1, 3'd2: e.res = wm ? b * 64'h0101010101010101
                                   : sx32(b[31:0] * 32'h01010101);
            3'd3, 3'd4: e.res = wm ? {48'd0, h} * 64'h0001000100010001
                                   : sx32({16'd0, h} * 32'h00010001);
            default: e.res = {w, w};
        endcase
        return e;
    endfunction

    task automatic drive(logic [2:0] op, logic wm, logic [63:0] a,
                         logic [9:0] im, logic [4:0] d);
        @(negedge clk);
        op_sel = op; wide_mode = wm; opnd = a; imm_field = im; dst_idx = d;
        sb_q.push_back(model(op, wm, a, im, d));
    endtask

    always @(posedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if (result !== e.res || wr_en !== e.we || illegal !== e.ill) begin
                n_fails++;
                $display("FAIL %s op=%0d wide=%0b: got res=%h we=%b ill=%b, expected res=%h we=%b ill=%b",
                         e.tag, op_sel, wide_mode, result, wr_en, illegal, e.res, e.we, e.ill);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state: idle inputs give a quiet unit (R8)
        n_checks++;
        if (result !== 64'd0 || wr_en !== 1'b0 || illegal !== 1'b0) begin
            n_fails++;
            $display("FAIL R8 reset: got res=%h we=%b ill=%b, expected 0 0 0", result, wr_en, illegal);
        end
        rst = 1'b0;

        // R1 bit reverse, upper bits discarded
        drive(3'd0, 1'b1, 64'hFFFF_FFFF_FFFF_0001, 10'd0, 5'd3);
        drive(3'd0, 1'b0, 64'h1234_5678_9ABC_8000, 10'd0, 5'd3);
        drive(3'd0, 1'b1, 64'h0000_0000_0000_A5C3, 10'd0, 5'd1);
        // R2 immediate byte, top bit set in narrow mode
        drive(3'd1, 1'b0, 64'd0, 10'h3A5, 5'd2);
        drive(3'd1, 1'b1, 64'd0, 10'h07F, 5'd2);
        // R3 register byte
        drive(3'd2, 1'b1, 64'hDEAD_BEEF_0000_00C4, 10'd0, 5'd7);
        drive(3'd2, 1'b0, 64'h0000_0000_0000_0041, 10'd0, 5'd7);
        // R4 immediate halfword and word with bit 9 set and clear
        drive(3'd3, 1'b1, 64'd0, 10'h200, 5'd9);
        drive(3'd3, 1'b0, 64'd0, 10'h1FF, 5'd9);
        drive(3'd5, 1'b1, 64'd0, 10'h3FF, 5'd9);
        drive(3'd5, 1'b1, 64'd0, 10'h155, 5'd9);
        // R5 register halfword
        drive(3'd4, 1'b1, 64'h0000_0000_0000_8001, 10'd0, 5'd4);
        drive(3'd4, 1'b0, 64'hFFFF_0000_0000_7FFE, 10'd0, 5'd4);
        // R6 register word
        drive(3'd6, 1'b1, 64'h1111_2222_8765_4321, 10'd0, 5'd31);
        // R8 zero destination
        drive(3'd2, 1'b1, 64'hFF, 10'd0, 5'd0);
        drive(3'd0, 1'b0, 64'hFFFF, 10'd0, 5'd0);
        // R9 word ops in narrow mode and reserved code
        drive(3'd5, 1'b0, 64'd0, 10'h3FF, 5'd5);
        drive(3'd6, 1'b0, 64'hFFFF_FFFF, 10'd0, 5'd5);
        drive(3'd7, 1'b1, 64'hFFFF_FFFF, 10'h3FF, 5'd5);
        // R10 random mix across all codes and modes
        for (int n = 0; n < N_RANDOM; n++) begin
            logic [4:0] d;
            d = ($urandom_range(0, 9) == 0) ? 5'd0 : 5'($urandom_range(1, 31));
            drive(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                  {$urandom, $urandom}, 10'($urandom_range(0, 1023)), d);
        end
        while (sb_q.size() > 0) @(negedge clk);
        finish_run();
    end

endmodule